// File: doc/BRIEF.md
# Cascaded Two-Channel 32-bit Free-Running Counter

This block builds a wide free-running count out of two narrow up-counting channels. The low channel counts ticks of a prescaler. The prescaler divides the system clock by a factor chosen at the `div_sel` input. A square wave follows the low count: it goes high when the count passes through zero and low when the count reaches the midpoint of its range. The high channel treats each rising edge of that wave as its clock. Both halves therefore live in the system clock domain, and the high half advances once for every full turn of the low half.

A reader pulses `rd_req`. The block then samples the high half, then the low half, then the high half again. If the two high samples differ, it samples again. When they agree, it returns `{high, low}` on `rd_data` with a one-cycle `rd_valid` strobe. The result stays coherent even though the high half trails the low half by one clock at a wrap. The `sync_clr` input restarts the prescaler and both channels together.

Top module: `casc_counter`

## Requirements
- R1: After reset, both halves and the prescaler are zero, `wave` is high and `rd_valid` is low. A read issued at once with `div_sel`=3 returns 0.
- R2: `div_sel` values 0, 1, 2 and 3 make the low half advance once every 2, 8, 32 and 128 system clocks. The first advance comes on the divisor-th clock edge after a restart.
- R3: The low half is a HALF_W-bit up-counter that steps by one per prescaler tick and wraps from all-ones to zero.
- R4: `wave` is high while the low half lies in 0 to 2^(HALF_W-1)-1 and low while it lies in 2^(HALF_W-1) to 2^HALF_W-1. It is set at low value 0 and cleared at low value 2^(HALF_W-1).
- R5: The high half steps by one on each rising edge of `wave`, one clock after that edge. Thus after 256 low-half ticks with HALF_W=8, a read returns 0x0100.
- R6: A read returns `{high, low}` from an upper/lower/upper sampling that repeats until both upper samples match. The value lies between the count when the request was taken and the count when `rd_valid` rose.
- R7: `rd_valid` lasts exactly one cycle and comes no sooner than the third edge after the request edge. `rd_req` is ignored while a read is in progress.
- R8: `sync_clr` clears the prescaler and both halves and sets `wave` high at the next edge. This restart never advances the high half.
- R9: Reads made back to back across a wrap of the low half never return a value below an earlier read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Prescaler choice: divide by 2^(2*div_sel+1) |
| sync_clr | input | 1 | Synchronous restart of prescaler and both channels |
| rd_req | input | 1 | Starts a coherent read when idle |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| rd_data | output | 2*HALF_W | Coherent count `{high, low}` |
| wave | output | 1 | Square wave from the low channel, high over the lower half of its range |

## Verification
The checker assumes a few things about `sync_clr` and `rd_req`. It assumes the only disturbance to the halves is `sync_clr`, so any other change must be a +1 step. It assumes `rd_req` pulses arrive cleanly so that strobes stay single-cycle. The stimulus changes `div_sel` only together with a `sync_clr`, so each closed-form count is taken from a known restart. It drives every input half a period away from the active edge. Reads are placed both at quiet moments, where an exact count is predicted, and in a back-to-back burst across a low-half wrap, where only ordering and range are predicted.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int HALF_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEL_W-1:0]      div_sel,
  input  logic                  sync_clr,
  input  logic                  rd_req,
  output logic                  rd_valid,
  output logic [2*HALF_W-1:0]   rd_data,
  output logic                  wave
);
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1) + 1;
  localparam logic [HALF_W-1:0] CMP_SET = '0;
  localparam logic [HALF_W-1:0] CMP_CLR = HALF_W'(1) << (HALF_W - 1);

  typedef enum logic [1:0] {RD_IDLE, RD_LO, RD_CHK} rd_st_t;

  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W:0]    span;
  logic              tick;
  logic [HALF_W-1:0] lo_cnt, hi_cnt, lo_nxt;
  logic              wave_d;
  logic              wave_rise;
  rd_st_t            rd_st;
  logic [HALF_W-1:0] up_smp, lo_smp;

  assign span      = ((PRE_W+1)'(1) << {div_sel, 1'b1}) - (PRE_W+1)'(1);
  assign tick      = {1'b0, pre_cnt} >= span;
  assign lo_nxt    = lo_cnt + HALF_W'(1);
  assign wave_rise = wave & ~wave_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      lo_cnt  <= '0;
      wave    <= 1'b1;
    end else if (sync_clr) begin
      pre_cnt <= '0;
      lo_cnt  <= '0;
      wave    <= 1'b1;
    end else if (tick) begin
      pre_cnt <= '0;
      lo_cnt  <= lo_nxt;
      if (lo_nxt == CMP_SET)      wave <= 1'b1;
      else if (lo_nxt == CMP_CLR) wave <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_d <= 1'b1;
      hi_cnt <= '0;
    end else if (sync_clr) begin
      wave_d <= 1'b1;
      hi_cnt <= '0;
    end else begin
      wave_d <= wave;
      if (wave_rise) hi_cnt <= hi_cnt + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_st    <= RD_IDLE;
      up_smp   <= '0;
      lo_smp   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (rd_st)
        RD_IDLE: if (rd_req) begin
          up_smp <= hi_cnt;
          rd_st  <= RD_LO;
        end
        RD_LO: begin
          lo_smp <= lo_cnt;
          rd_st  <= RD_CHK;
        end
        default: begin
          if (hi_cnt == up_smp) begin
            rd_data  <= {up_smp, lo_smp};
            rd_valid <= 1'b1;
            rd_st    <= RD_IDLE;
          end else begin
            up_smp <= hi_cnt;
            rd_st  <= RD_LO;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_clr,
  input logic              rd_valid,
  input logic              wave,
  input logic [HALF_W-1:0] lo_cnt,
  input logic [HALF_W-1:0] hi_cnt
);
  p_lo_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt != $past(lo_cnt)) && !$past(sync_clr) |-> lo_cnt == $past(lo_cnt) + HALF_W'(1));

  p_wave_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wave == !lo_cnt[HALF_W-1]);

  p_hi_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt != $past(hi_cnt)) && !$past(sync_clr) |-> hi_cnt == $past(hi_cnt) + HALF_W'(1));

  p_strobe_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (lo_cnt == '0) && (hi_cnt == '0) && wave);
endmodule

bind casc_counter casc_counter_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .rd_valid(rd_valid),
  .wave(wave), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
);

// File: tb/tb_casc_counter.sv
module tb_casc_counter;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int CW = 2 * HW;
  localparam int NVEC = 6;
  localparam logic [1:0]  VSEL  [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam int          VWAIT [NVEC] = '{37, 100, 300, 700, 600, 2100};

  logic clk = 1'b0, rst_n = 1'b0, sync_clr = 1'b0, rd_req = 1'b0;
  logic [1:0] div_sel = 2'd3;
  logic rd_valid, wave;
  logic [CW-1:0] rd_data;
  int checks = 0, failures = 0, cyc = 0;
  int m_pre = 0;
  logic [CW-1:0] m_cnt = '0;

  casc_counter #(.HALF_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .sync_clr(sync_clr),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .wave(wave));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin m_pre <= 0; m_cnt <= '0; end
    else if (sync_clr) begin m_pre <= 0; m_cnt <= '0; end
    else if (m_pre >= (1 << (2*div_sel+1)) - 1) begin m_pre <= 0; m_cnt <= m_cnt + 1'b1; end
    else m_pre <= m_pre + 1;
  end

  always @(negedge clk) if (cyc > 150000) begin
    failures++;
    $display("FAIL watchdog: run hung, cyc=%0d expected<=150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] sel);
    @(negedge clk); div_sel = sel; sync_clr = 1'b1;
    @(negedge clk); sync_clr = 1'b0;
  endtask

  task automatic do_read(output logic [CW-1:0] d, output logic [CW-1:0] lo_b, output logic [CW-1:0] hi_b);
    @(negedge clk); rd_req = 1'b1; lo_b = m_cnt;
    @(negedge clk); rd_req = 1'b0;
    for (int i = 0; i < 50 && !rd_valid; i++) @(negedge clk);
    d = rd_data; hi_b = m_cnt;
  endtask

  logic [CW-1:0] d, lb, hb, prev;
  int pulses;

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    chk(wave == 1'b1, "R1 wave after reset", wave, 1);
    rst_n = 1'b1;
    do_read(d, lb, hb);
    chk(d == 0, "R1 first read", d, 0);

    // R6 table walk
    for (int v = 0; v < NVEC; v++) begin
      restart(VSEL[v]);
      repeat (VWAIT[v]) @(negedge clk);
      do_read(d, lb, hb);
      chk(d >= lb && d <= hb, "R6 read window", d, lb);
      chk(wave == (m_cnt[HW-1] == 1'b0), "R4 wave level", wave, !m_cnt[HW-1]);
    end

    // R2 exact counts from restart
    restart(2'd2); repeat (227) @(negedge clk);
    do_read(d, lb, hb); chk(d == 7, "R2 div32 count", d, 7);
    restart(2'd3); repeat (650) @(negedge clk);
    do_read(d, lb, hb); chk(d == 5, "R2 div128 count", d, 5);
    restart(2'd0); repeat (21) @(negedge clk);
    do_read(d, lb, hb); chk(d == 11, "R2 div2 count", d, 11);

    // R3 R5 wrap into high half
    restart(2'd1); repeat (2052) @(negedge clk);
    do_read(d, lb, hb); chk(d == 16'h0100, "R3 R5 carry via wave", d, 16'h0100);

    // R4 wave low in upper half, R8 restart
    restart(2'd0); repeat (300) @(negedge clk);
    chk(wave == 1'b0, "R4 wave low at count 150", wave, 0);
    restart(2'd3);
    chk(wave == 1'b1, "R8 wave set by restart", wave, 1);
    do_read(d, lb, hb); chk(d == 0, "R8 count cleared", d, 0);

    // R7 busy request ignored, single strobe
    pulses = 0;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b1; if (rd_valid) pulses++;
    @(negedge clk); rd_req = 1'b0; if (rd_valid) pulses++;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (rd_valid) pulses++; end
    chk(pulses == 1, "R7 one strobe per read", pulses, 1);

    // R9 burst across low-half wraps
    restart(2'd0); repeat (490) @(negedge clk);
    prev = '0;
    for (int i = 0; i < 40; i++) begin
      do_read(d, lb, hb);
      chk(d >= prev && d >= lb && d <= hb, "R9 monotonic across wrap", d, prev);
      prev = d;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule